// File: doc/BRIEF.md
# External Bus Width-Adapting Byte Steerer

This block connects a 32-bit internal requester to an external data bus whose width is fixed by a static strap, `port16`, to either 32 or 16 bits. Each request carries a two-bit size code and a byte address. Write bytes are placed on the external lanes that the address and port width call for. Read bytes are collected from those lanes and returned as one big-endian internal word.

When a full word targets the 16-bit port, the block runs two external half-word cycles back to back, and the requester sees only one acknowledge. Requests whose size is reserved or whose address is misaligned end with an error response and produce no external cycle.

Bit conventions: internal byte offset 0 is bits [31:24] and offset 3 is bits [7:0]. External lane D0:D7 is `ext_wdata`/`ext_rdata` bits [31:24], D8:D15 is [23:16], D16:D23 is [15:8] and D24:D31 is [7:0]. `ext_be[3]` marks lane D0:D7 and `ext_be[0]` marks D24:D31. Size codes are 01 for a byte, 10 for a half-word, 00 for a word, and 11 is reserved. Both handshakes are level-held requests: `req_valid` stays high until the cycle after a one-cycle `req_ack` or `req_err`, and `ext_req` stays high until the cycle after `ext_ack`.

Top module: `bus_size_steer`

## Requirements
- R1: A request is rejected with a one-cycle `req_err` pulse, and `ext_req` never rises for it, in three cases: size code 11, a half-word at an odd address, or a word whose address bits [1:0] are not 00.
- R2: On the 32-bit port, a byte write at offset o drives `ext_be` with only bit 3-o set, and places the byte on that lane.
- R3: On the 32-bit port, a half-word write drives `ext_be`=1100 with bytes 0-1 on bits [31:16] at offset 0. At offset 2 it drives `ext_be`=0011 with bytes 2-3 on bits [15:0].
- R4: On the 32-bit port, a word access is one external cycle with `ext_be`=1111 and the word unchanged on the bus.
- R5: On the 16-bit port, a byte at an even offset uses lane D0:D7 with `ext_be`=1000, and a byte at an odd offset uses lane D8:D15 with `ext_be`=0100.
- R6: On the 16-bit port, a half-word at offset 0 or 2 is carried on bits [31:16] with `ext_be`=1100.
- R7: On the 16-bit port, a word becomes two external cycles. The first uses the request address and carries bytes 0-1. The second uses the address with bit 1 set and carries bytes 2-3. Both use `ext_be`=1100.
- R8: A read returns the addressed bytes at their internal offsets and zeros elsewhere. Data on lanes outside `ext_be` does not affect the result.
- R9: `req_ack` is a single-cycle pulse that follows the final `ext_ack` of the access. `ext_req` stays high through external wait cycles.
- R10: After reset, `ext_req`, `ext_be`, `req_ack` and `req_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port16 | input | 1 | Static strap: 1 selects the 16-bit external port |
| req_valid | input | 1 | Internal request, held until acknowledged |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Size code: 01 byte, 10 half-word, 00 word, 11 reserved |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Big-endian write word |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle rejection pulse |
| req_rdata | output | 32 | Assembled read word, valid with `req_ack` |
| ext_req | output | 1 | External cycle request |
| ext_write | output | 1 | External cycle direction |
| ext_addr | output | AW | External cycle address |
| ext_wdata | output | 32 | External write lanes |
| ext_be | output | 4 | Valid-lane mask, bit 3 = D0:D7 |
| ext_ack | input | 1 | External cycle completion |
| ext_rdata | input | 32 | External read lanes |

## Verification
The bench targets the second half of a split word. A design that failed to set address bit 1 there, or that reused bytes 0-1, would write the wrong half to memory. A design that acknowledged early would return a read word with only two bytes filled.

The bench fills unselected read lanes with junk, so a design that copied all lanes would leak that junk into the result. It also steers odd bytes on the narrow port, where a swapped lane mapping would put the byte on D0:D7. It checks misaligned and reserved requests, where a missing check would start an external cycle instead of returning an error.

// File: rtl/bus_size_steer.sv
module bus_size_steer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port16,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ack,
  output logic          req_err,
  output logic [31:0]   req_rdata,
  output logic          ext_req,
  output logic          ext_write,
  output logic [AW-1:0] ext_addr,
  output logic [31:0]   ext_wdata,
  output logic [3:0]    ext_be,
  input  logic          ext_ack,
  input  logic [31:0]   ext_rdata
);
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} state_t;
  state_t st;

  logic          wr_q, phase;
  logic [1:0]    size_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rdata_q, rd_next;

  wire bad = (req_size == 2'b11) ||
             (req_size == SZ_HALF && req_addr[0]) ||
             (req_size == SZ_WORD && req_addr[1:0] != 2'b00);
  wire split = port16 && size_q == SZ_WORD;

  assign ext_req   = (st == S_BUSY);
  assign ext_write = wr_q;
  assign ext_addr  = {addr_q[AW-1:2], addr_q[1] | phase, addr_q[0]};
  assign req_rdata = rdata_q;

  wire [1:0] off  = ext_addr[1:0];
  wire [7:0] byt  = wdata_q[{~off, 3'b000} +: 8];
  wire [15:0] hw  = off[1] ? wdata_q[15:0] : wdata_q[31:16];

  logic [3:0] be;
  always_comb begin
    if (port16)
      be = (size_q == SZ_BYTE) ? (off[0] ? 4'b0100 : 4'b1000) : 4'b1100;
    else if (size_q == SZ_BYTE)
      be = 4'b1000 >> off;
    else if (size_q == SZ_HALF)
      be = off[1] ? 4'b0011 : 4'b1100;
    else
      be = 4'b1111;
  end
  assign ext_be    = ext_req ? be : 4'b0000;
  assign ext_wdata = !port16 ? wdata_q :
                     (size_q == SZ_BYTE) ? {4{byt}} : {2{hw}};

  wire [31:0] src  = port16 ? {2{ext_rdata[31:16]}} : ext_rdata;
  wire [3:0]  t16  = off[1] ? {2'b00, ext_be[3:2]} : {ext_be[3:2], 2'b00};
  wire [3:0]  take = wr_q ? 4'b0000 : (port16 ? t16 : ext_be);

  always_comb
    for (int k = 0; k < 4; k++)
      rd_next[8*k +: 8] = take[k] ? src[8*k +: 8] : rdata_q[8*k +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      req_ack <= 1'b0;
      req_err <= 1'b0;
      phase   <= 1'b0;
      wr_q    <= 1'b0;
      size_q  <= SZ_WORD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      req_ack <= 1'b0;
      req_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad) begin
            req_err <= 1'b1;
            st      <= S_RESP;
          end else begin
            wr_q    <= req_write;
            size_q  <= req_size;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            phase   <= 1'b0;
            st      <= S_BUSY;
          end
        end
        S_BUSY: if (ext_ack) begin
          rdata_q <= rd_next;
          if (split && !phase) phase <= 1'b1;
          else begin
            req_ack <= 1'b1;
            st      <= S_RESP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !ext_req);
  a_r1_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && req_err));
  a_r5_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && port16) |-> ext_be[1:0] == 2'b00);
  a_r2_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && size_q == SZ_BYTE) |-> $countones(ext_be) == 1);
  a_r7_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack && split && !phase) |=> (ext_req && ext_addr[1]));
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> ext_req);
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
endmodule

// File: tb/bus_size_steer_tb.sv
module bus_size_steer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, port16 = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ack, req_err, ext_req, ext_write;
  logic [31:0] req_rdata, ext_wdata;
  logic [AW-1:0] ext_addr;
  logic [3:0] ext_be;
  logic ext_ack = 1'b0;
  logic [31:0] ext_rdata = '0;

  int errors = 0, checks = 0;
  int ntx;
  logic [AW-1:0] tx_addr [0:3];
  logic [31:0]   tx_wdata [0:3];
  logic [3:0]    tx_be [0:3];
  logic [31:0]   sl_rd [0:3];
  logic          got_ack, got_err, pulse_ok, held_ok;
  logic [31:0]   got_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_size_steer #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .port16(port16),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
    .ext_req(ext_req), .ext_write(ext_write), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_be(ext_be),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata));

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic [3:0] b);
    for (int k = 0; k < 4; k++) lmask[8*k +: 8] = {8{b[k]}};
  endfunction

  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, input int wait_n);
    int wc = 0, cyc = 0;
    logic done = 1'b0;
    ntx = 0; got_ack = 0; got_err = 0; pulse_ok = 1; held_ok = 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (ext_ack) ext_ack = 0;
      else if (wc > 0 && !ext_req) held_ok = 0;
      if (req_ack || req_err) begin
        got_ack = req_ack; got_err = req_err; got_rdata = req_rdata;
        req_valid = 0; done = 1;
        @(negedge clk);
        if (req_ack || req_err) pulse_ok = 0;
      end else if (ext_req) begin
        if (wc == wait_n) begin
          if (ntx < 4) begin
            tx_addr[ntx] = ext_addr; tx_wdata[ntx] = ext_wdata; tx_be[ntx] = ext_be;
            ext_rdata = sl_rd[ntx];
          end
          ntx++; ext_ack = 1; wc = 0;
        end else wc++;
      end
      if (cyc > 60) begin
        chk(0, "timeout", 0, 1);
        req_valid = 0; done = 1;
      end
    end
  endtask

  task automatic t_reset();
    chk(!ext_req && ext_be == 0 && !req_ack && !req_err, "R10 reset outputs",
        {ext_req, ext_be, req_ack, req_err}, 0);
  endtask

  task automatic t_errors();
    port16 = 0;
    xfer(1, 2'b11, 32'h100, 32'h0, 0);
    chk(got_err && !got_ack && ntx == 0, "R1 reserved size", ntx, 0);
    xfer(0, 2'b10, 32'h101, 32'h0, 0);
    chk(got_err && ntx == 0, "R1 odd half", ntx, 0);
    port16 = 1;
    xfer(1, 2'b00, 32'h102, 32'h0, 0);
    chk(got_err && ntx == 0 && pulse_ok, "R1 misaligned word", ntx, 0);
    port16 = 0;
  endtask

  task automatic t_wide_bytes();
    port16 = 0;
    for (int o = 0; o < 4; o++) begin
      logic [3:0] eb;
      eb = 4'b1000 >> o;
      xfer(1, 2'b01, 32'h200 + o, 32'h11223344, 0);
      chk(ntx == 1 && tx_be[0] == eb, "R2 byte be", tx_be[0], eb);
      chk((tx_wdata[0] & lmask(eb)) == (32'h11223344 & lmask(eb)), "R2 byte lane",
          tx_wdata[0], 32'h11223344);
    end
    sl_rd[0] = 32'hA1B2C3D4;
    xfer(0, 2'b01, 32'h201, 0, 0);
    chk(got_ack && got_rdata == 32'h00B20000, "R8 wide byte read", got_rdata, 32'h00B20000);
  endtask

  task automatic t_wide_half_word();
    port16 = 0;
    xfer(1, 2'b10, 32'h300, 32'hCAFEF00D, 0);
    chk(tx_be[0] == 4'b1100 && tx_wdata[0][31:16] == 16'hCAFE, "R3 half off0",
        {tx_be[0], tx_wdata[0]}, {4'b1100, 32'hCAFEF00D});
    xfer(1, 2'b10, 32'h302, 32'hCAFEF00D, 0);
    chk(tx_be[0] == 4'b0011 && tx_wdata[0][15:0] == 16'hF00D, "R3 half off2",
        {tx_be[0], tx_wdata[0]}, {4'b0011, 32'hCAFEF00D});
    sl_rd[0] = 32'hDEADBEEF;
    xfer(0, 2'b10, 32'h302, 0, 0);
    chk(got_rdata == 32'h0000BEEF, "R8 wide half read", got_rdata, 32'h0000BEEF);
    xfer(1, 2'b00, 32'h304, 32'h0BADC0DE, 0);
    chk(ntx == 1 && tx_be[0] == 4'hF && tx_wdata[0] == 32'h0BADC0DE && tx_addr[0] == 32'h304,
        "R4 word one cycle", {ntx[3:0], tx_wdata[0]}, {4'd1, 32'h0BADC0DE});
  endtask

  task automatic t_narrow_bytes_half();
    port16 = 1;
    xfer(1, 2'b01, 32'h402, 32'h11223344, 0);
    chk(tx_be[0] == 4'b1000 && tx_wdata[0][31:24] == 8'h33, "R5 even byte",
        {tx_be[0], tx_wdata[0]}, {4'b1000, 32'h33000000});
    xfer(1, 2'b01, 32'h401, 32'h11223344, 0);
    chk(tx_be[0] == 4'b0100 && tx_wdata[0][23:16] == 8'h22, "R5 odd byte",
        {tx_be[0], tx_wdata[0]}, {4'b0100, 32'h00220000});
    sl_rd[0] = 32'h778899AA;
    xfer(0, 2'b01, 32'h403, 0, 0);
    chk(got_rdata == 32'h00000088, "R8 narrow odd byte read", got_rdata, 32'h00000088);
    xfer(1, 2'b10, 32'h402, 32'hCAFEF00D, 0);
    chk(ntx == 1 && tx_be[0] == 4'b1100 && tx_wdata[0][31:16] == 16'hF00D, "R6 narrow half",
        {tx_be[0], tx_wdata[0]}, {4'b1100, 32'hF00D0000});
  endtask

  task automatic t_narrow_word();
    port16 = 1;
    xfer(1, 2'b00, 32'h500, 32'h0BADC0DE, 0);
    chk(ntx == 2 && got_ack, "R7 two cycles", ntx, 2);
    chk(tx_addr[0] == 32'h500 && tx_wdata[0][31:16] == 16'h0BAD && tx_be[0] == 4'b1100,
        "R7 first half", {tx_addr[0], tx_wdata[0]}, {32'h500, 32'h0BAD0000});
    chk(tx_addr[1] == 32'h502 && tx_wdata[1][31:16] == 16'hC0DE && tx_be[1] == 4'b1100,
        "R7 second half", {tx_addr[1], tx_wdata[1]}, {32'h502, 32'hC0DE0000});
    sl_rd[0] = 32'h11225A5A; sl_rd[1] = 32'h3344A5A5;
    xfer(0, 2'b00, 32'h500, 0, 2);
    chk(ntx == 2 && got_rdata == 32'h11223344, "R8 split read assembled", got_rdata, 32'h11223344);
    chk(pulse_ok && held_ok, "R9 ack pulse and held request", {pulse_ok, held_ok}, 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_errors();
    t_wide_bytes();
    t_wide_half_word();
    t_narrow_bytes_half();
    t_narrow_word();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule